// File: doc/BRIEF.md
# Codec Warm Reset Pulse Generator

This block drives a timed wake-up pulse onto the frame-sync line of a serial audio codec. Software starts it by writing 1 to a self-clearing control bit. The block then forces the sync line high for a fixed number of system clocks. The same bit reads back as 1 while the pulse runs and falls back to 0 by itself when the pulse ends.

A request only takes effect when two conditions hold. The link must not be shut down, and the codec bit clock must be idle. The block judges the bit clock idle after a two-stage synchronizer has seen no edge on it for a set number of system clocks. A request that arrives when either condition fails is dropped without any trace. A request that arrives while a pulse is already running is also dropped. The codec frame protocol itself lies outside this block.

Top module: `wrst_gen`

## Requirements
- R1: After a synchronous reset, `sync_o` is 0 and every bit of `rd_data` is 0.
- R2: A write (`wr_en`=1) with bit 2 of `wr_data` set is accepted when `link_off`=0 and the bit clock is idle. `sync_o` then goes high at the clock edge that takes the write. It stays high for exactly `PULSE_LEN` (default 32) consecutive cycles and then returns low.
- R3: Bit 2 of `rd_data` reads 1 in exactly the cycles where `sync_o` is high. All other bits of `rd_data` always read 0.
- R4: A write made while `link_off`=1 has no effect, and `sync_o` and `rd_data` stay 0.
- R5: The bit clock counts as idle only after its synchronized copy has shown no edge for `IDLE_CYCLES` (default 16) system clocks. A write made while `bclk` is toggling has no effect.
- R6: A write whose bit 2 is 0 starts no pulse, whatever the other bits hold.
- R7: A write of 1 to bit 2 during a running pulse neither restarts nor lengthens it. The total high time stays `PULSE_LEN` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data; bit 2 requests a warm reset |
| link_off | input | 1 | Link shutdown status; 1 blocks requests |
| bclk | input | 1 | Codec bit clock, asynchronous to `clk` |
| sync_o | output | 1 | Sync line override, high during the pulse |
| rd_data | output | 8 | Register readback; bit 2 shows that a pulse is running |

## Verification
The hardest case to reach is a second request arriving in the middle of a running pulse. It only means something if the bench can show that the pulse was not stretched. The bench first holds the bit clock quiet long enough to pass the idle threshold, then starts a pulse. Ten cycles later it writes the bit again and counts every high cycle of `sync_o` over a window much longer than the pulse. The bench also reaches the refusal paths by toggling `bclk` on every cycle up to and through the write, which keeps the idle detector from ever reaching its threshold.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_CTL_BIT     = 2;
  localparam int unsigned DEF_PULSE_LEN   = 32;
  localparam int unsigned DEF_IDLE_CYCLES = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Width of a counter that must hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/wrst_idle_det.sv
module wrst_idle_det #(
  parameter int unsigned SYNC_STAGES = wrst_pkg::DEF_SYNC_STAGES,
  parameter int unsigned IDLE_CYCLES = wrst_pkg::DEF_IDLE_CYCLES
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  output logic idle_o
);
  localparam int unsigned CW = wrst_pkg::cnt_width(IDLE_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  // Synchronizer chain plus one stage to compare against.
  logic [SYNC_STAGES:0] sh_q;
  logic                 edge_seen;
  logic [CW-1:0]        quiet_q, quiet_d;
  logic                 idle_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], bclk_i};
  end

  assign edge_seen = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

  always_comb begin
    if (edge_seen)             quiet_d = '0;
    else if (quiet_q != LIMIT) quiet_d = quiet_q + 1'b1;
    else                       quiet_d = quiet_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= '0;
      idle_q  <= 1'b0;
    end else begin
      quiet_q <= quiet_d;
      idle_q  <= (quiet_d == LIMIT);
    end
  end

  assign idle_o = idle_q;

  // R5
  bclk_edge_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> !idle_o);

  // R5
  quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
    quiet_q <= LIMIT);
endmodule

// File: rtl/wrst_pulse.sv
module wrst_pulse #(
  parameter int unsigned PULSE_LEN = wrst_pkg::DEF_PULSE_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic allow_i,
  output logic pulse_o
);
  localparam int unsigned CW = wrst_pkg::cnt_width(PULSE_LEN);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_q;
  logic          running;
  logic          accept;

  assign running = (cnt_q != '0);
  assign accept  = req_i && allow_i && !running;

  always_comb begin
    if (accept)       cnt_d = LOAD;
    else if (running) cnt_d = cnt_q - 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= (cnt_d != '0);
    end
  end

  assign pulse_o = pulse_q;

  // R2
  pulse_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    running |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2
  rise_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(req_i && allow_i));
endmodule

// File: rtl/wrst_gen.sv
module wrst_gen #(
  parameter int unsigned DATA_W      = wrst_pkg::DEF_DATA_W,
  parameter int unsigned CTL_BIT     = wrst_pkg::DEF_CTL_BIT,
  parameter int unsigned PULSE_LEN   = wrst_pkg::DEF_PULSE_LEN,
  parameter int unsigned IDLE_CYCLES = wrst_pkg::DEF_IDLE_CYCLES,
  parameter int unsigned SYNC_STAGES = wrst_pkg::DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              link_off,
  input  logic              bclk,
  output logic              sync_o,
  output logic [DATA_W-1:0] rd_data
);
  logic bclk_idle;
  logic pulse;

  wrst_idle_det #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_idle (
    .clk   (clk),
    .rst   (rst),
    .bclk_i(bclk),
    .idle_o(bclk_idle)
  );

  wrst_pulse #(
    .PULSE_LEN(PULSE_LEN)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .req_i  (wr_en && wr_data[CTL_BIT]),
    .allow_i(bclk_idle && !link_off),
    .pulse_o(pulse)
  );

  assign sync_o = pulse;

  always_comb begin
    rd_data          = '0;
    rd_data[CTL_BIT] = pulse;
  end

  // R4
  link_off_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (link_off && !sync_o) |=> !sync_o);

  // R6
  zero_bit_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_o && !(wr_en && wr_data[CTL_BIT])) |=> !sync_o);
endmodule

// File: tb/wrst_gen_tb.sv
module wrst_gen_tb;
  localparam int PLEN = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       link_off = 1'b0;
  logic       bclk = 1'b0;
  logic       sync_o;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit toggling = 1'b0;

  always #10 clk = ~clk;

  wrst_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .link_off(link_off), .bclk(bclk), .sync_o(sync_o), .rd_data(rd_data)
  );

  // Vector fields: [10] link_off, [9] bclk toggling, [8] pulse expected, [7:0] data
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b1, 8'h04},   // R2 accepted
    {1'b1, 1'b0, 1'b0, 8'h04},   // R4 link shut down
    {1'b0, 1'b1, 1'b0, 8'h04},   // R5 bit clock running
    {1'b0, 1'b0, 1'b0, 8'hFB},   // R6 control bit clear
    {1'b0, 1'b0, 1'b1, 8'hFF},   // R2 other bits set too
    {1'b1, 1'b1, 1'b0, 8'h04}    // R4 and R5 both blocking
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (toggling) bclk = ~bclk;
  endtask

  // Samples n negedges; counts sync highs, first/last index, readback faults.
  task automatic observe(input int n, output int highs, output int first, output int last,
                         output int rd_bad);
    highs = 0; first = -1; last = -1; rd_bad = 0;
    for (int i = 0; i < n; i++) begin
      if (sync_o) begin
        highs++;
        if (first < 0) first = i;
        last = i;
      end
      if (rd_data[2] !== sync_o || (rd_data & 8'hFB) !== 8'h00) rd_bad++;
      step();
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int h, f, l, rb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sync_o === 1'b0, "R1 sync", sync_o, 0);
    check(rd_data === 8'h00, "R1 rd_data", rd_data, 0);
    rst = 1'b0;

    foreach (VEC[k]) begin
      link_off = VEC[k][10];
      toggling = VEC[k][9];
      repeat (30) step();
      wr_en = 1'b1; wr_data = VEC[k][7:0];
      @(posedge clk);
      @(negedge clk);
      if (toggling) bclk = ~bclk;
      wr_en = 1'b0; wr_data = '0;
      observe(45, h, f, l, rb);
      if (VEC[k][8]) begin
        check(h == PLEN, "R2 pulse length", h, PLEN);
        check(f == 0 && l == PLEN - 1, "R2 pulse position", l, PLEN - 1);
      end else begin
        check(h == 0, k == 3 ? "R6 no pulse" : "R4/R5 no pulse", h, 0);
      end
      check(rb == 0, "R3 readback", rb, 0);
      toggling = 1'b0;
      link_off = 1'b0;
    end

    // R7 second write mid-pulse
    repeat (30) step();
    wr_en = 1'b1; wr_data = 8'h04;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    observe(10, h, f, l, rb);
    wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    begin
      int h2, f2, l2, rb2;
      observe(50, h2, f2, l2, rb2);
      check(h + h2 + 1 == PLEN, "R7 total length", h + h2 + 1, PLEN);
      check(rb + rb2 == 0, "R3 readback during R7", rb + rb2, 0);
    end

    // R1 reset mid-pulse
    repeat (30) step();
    wr_en = 1'b1; wr_data = 8'h04;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(sync_o === 1'b0 && rd_data === 8'h00, "R1 reset mid-pulse", sync_o, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule